// File: doc/BRIEF.md
# Programmable Almost-Full Flag Generator

This block produces an active-low almost-full indication for a dual-clock FIFO. It keeps a write pointer in the write-clock domain. It keeps a read pointer in the read-clock domain and passes it into the write domain as Gray code through a two-stage synchronizer. It computes the FIFO occupancy from the two pointers and compares it with a threshold equal to the maximum depth minus a runtime-loaded offset. The flag is evaluated and registered only on write-clock edges.

The maximum depth depends on the output mode. In standard mode it equals the storage depth. In fall-through mode one extra word sits in the output register, so the maximum depth is one larger. A write is counted as soon as it is accepted. A read reaches the flag only after it has crossed the synchronizer, so the flag is released a fixed number of write-clock edges after the read.

The storage array and the empty and full outputs belong to the surrounding FIFO. The caller must not issue a read while the FIFO is empty. A single synchronous reset is held across edges of both clocks.

Top module: `af_flag_gen`

## Requirements
- R1: While `rst` is high on a write-clock edge, the occupancy returns to zero, the offset register returns to 0, and `paf_n` is 1 after that edge.
- R2: On the write-clock edge that accepts the write bringing the occupancy to D − m, `paf_n` becomes 0. D is the maximum depth and m is the loaded offset.
- R3: `paf_n` stays 0 while the occupancy seen by the write domain is D − m or more, including exactly D − m.
- R4: A read is seen by the flag at the third write-clock edge after the read-clock edge that takes it: two synchronizer stages, then the flag register. `paf_n` returns to 1 once the seen occupancy is D − m − 1 or less.
- R5: `paf_n` changes only on write-clock rising edges. A read-clock edge alone never moves it.
- R6: D equals `DEPTH` when `fwft_mode` is 0 and `DEPTH + 1` when `fwft_mode` is 1. The seen occupancy never exceeds D.
- R7: A write requested while the seen occupancy equals D is not counted.
- R8: `ld_offset` is captured on a write-clock edge where `ld_en` is 1. The flag computed on that same edge still uses the previous offset, and the new offset applies from the next edge.
- R9: An offset of D or more gives a threshold of zero, so `paf_n` is 0 at any occupancy, including empty.
- R10: The read pointer is carried across as Gray code. At most one of its bits changes per read-clock cycle.
- R11: When a write and a read fall in the same step, the write counts on that write edge and the read counts only after the latency of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| wr_en | input | 1 | Write request |
| ld_en | input | 1 | Load strobe for the offset register (write domain) |
| ld_offset | input | PW | Almost-full offset m |
| fwft_mode | input | 1 | 1 selects fall-through mode (depth + 1); change only under reset |
| clk_r | input | 1 | Read clock |
| rd_en | input | 1 | Read request; must not be issued while the FIFO is empty |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
A write and a read can fall in the same cycle. The write is counted at once, while the read passes through the synchronizer first. The bench drives both enables in one step when the occupancy sits one below the threshold. It then expects `paf_n` to go low on that step, stay low for one further step, and release on the step after. Each step also samples `paf_n` just before and just after the read-clock edge. Any movement there would show the flag reacting to the read clock.

// File: rtl/af_pkg.sv
package af_pkg;
  // Number of flops the read pointer crosses into the write domain
  localparam int unsigned AF_SYNC_STAGES = 2;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } af_mode_e;
endpackage

// File: rtl/af_gray2bin.sv
module af_gray2bin #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/af_sync.sv
module af_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/af_rd_ptr.sv
module af_rd_ptr #(
  parameter int unsigned PW = 4
) (
  input  logic          clk_r,
  input  logic          rst,
  input  logic          rd_en,
  output logic [PW-1:0] rgray
);
  logic [PW-1:0] rbin;
  logic [PW-1:0] rbin_nx;

  assign rbin_nx = rbin + PW'(rd_en);

  always_ff @(posedge clk_r) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  // R10
  gray_one_step_chk: assert property (@(posedge clk_r) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/af_wr_ctl.sv
module af_wr_ctl
  import af_pkg::*;
#(
  parameter int unsigned DEPTH = 32768,
  parameter int unsigned PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_w,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [PW-1:0] ld_offset,
  input  logic          fwft_mode,
  input  logic [PW-1:0] rbin_s,
  output logic          paf_n
);
  localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);

  af_mode_e      mode;
  logic [PW-1:0] depth_eff;
  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_nx;
  logic [PW-1:0] occ;
  logic [PW-1:0] occ_nx;
  logic [PW-1:0] off_q;
  logic [PW-1:0] thr;
  logic          full;
  logic          wr_ok;

  assign mode      = fwft_mode ? MODE_FWFT : MODE_STD;
  assign depth_eff = (mode == MODE_FWFT) ? DEPTH_W + PW'(1) : DEPTH_W;

  assign occ     = wptr - rbin_s;
  assign full    = (occ >= depth_eff);
  assign wr_ok   = wr_en && !full;
  assign wptr_nx = wptr + PW'(wr_ok);
  assign occ_nx  = wptr_nx - rbin_s;
  assign thr     = (off_q >= depth_eff) ? '0 : depth_eff - off_q;

  always_ff @(posedge clk_w) begin
    if (rst) begin
      wptr  <= '0;
      off_q <= '0;
      paf_n <= 1'b1;
    end else begin
      wptr  <= wptr_nx;
      paf_n <= !(occ_nx >= thr);
      if (ld_en) off_q <= ld_offset;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk_w)
    rst |=> (paf_n && wptr == '0));

  // R6
  occ_bound_chk: assert property (@(posedge clk_w) disable iff (rst)
    occ <= depth_eff);

  // R7
  full_write_drop_chk: assert property (@(posedge clk_w) disable iff (rst)
    full |=> $stable(wptr));
endmodule

// File: rtl/af_flag_gen.sv
module af_flag_gen
  import af_pkg::*;
#(
  parameter int unsigned DEPTH = 32768,
  parameter int unsigned PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_w,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [PW-1:0] ld_offset,
  input  logic          fwft_mode,
  input  logic          clk_r,
  input  logic          rd_en,
  output logic          paf_n
);
  logic [PW-1:0] rgray;
  logic [PW-1:0] rgray_s;
  logic [PW-1:0] rbin_s;

  af_rd_ptr #(.PW(PW)) u_rd_ptr (
    .clk_r (clk_r),
    .rst   (rst),
    .rd_en (rd_en),
    .rgray (rgray)
  );

  af_sync #(.W(PW), .STAGES(AF_SYNC_STAGES)) u_sync (
    .clk (clk_w),
    .rst (rst),
    .d   (rgray),
    .q   (rgray_s)
  );

  af_gray2bin #(.W(PW)) u_g2b (
    .gray (rgray_s),
    .bin  (rbin_s)
  );

  af_wr_ctl #(.DEPTH(DEPTH), .PW(PW)) u_wr_ctl (
    .clk_w     (clk_w),
    .rst       (rst),
    .wr_en     (wr_en),
    .ld_en     (ld_en),
    .ld_offset (ld_offset),
    .fwft_mode (fwft_mode),
    .rbin_s    (rbin_s),
    .paf_n     (paf_n)
  );
endmodule

// File: tb/tb_af_flag_gen.sv
`timescale 1ns/1ps
module tb_af_flag_gen;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned PW    = $clog2(DEPTH) + 1;

  logic          clk_w = 1'b0;
  logic          clk_r = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic          ld_en = 1'b0;
  logic [PW-1:0] ld_offset = '0;
  logic          fwft_mode = 1'b0;
  logic          paf_n;

  int n_checks = 0;
  int n_fail   = 0;

  af_flag_gen #(.DEPTH(DEPTH), .PW(PW)) dut (
    .clk_w     (clk_w),
    .rst       (rst),
    .wr_en     (wr_en),
    .ld_en     (ld_en),
    .ld_offset (ld_offset),
    .fwft_mode (fwft_mode),
    .clk_r     (clk_r),
    .rd_en     (rd_en),
    .paf_n     (paf_n)
  );

  // 200 MHz write clock; read clock at the same rate, rising 1.25 ns before each write edge
  initial forever #2.5 clk_w = ~clk_w;
  initial begin
    #1.25 clk_r = 1'b1;
    forever #2.5 clk_r = ~clk_r;
  end

  typedef struct packed {
    logic [3:0] n;
    logic       wr;
    logic       rd;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // Standard mode, DEPTH 8, offset 2: threshold 6
  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd5, 1'b1, 1'b0, 1'b1, 4'd2},  // R2 occupancy 5, below threshold
    '{4'd1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 occupancy 6 asserts on the write edge
    '{4'd1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 read not yet seen
    '{4'd1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 still in the synchronizer
    '{4'd1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 released, occupancy 5
    '{4'd3, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 occupancy 8 (full)
    '{4'd4, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 writes while full
    '{4'd3, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 one read seen, occupancy 7
    '{4'd1, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 exactly D-m still low
    '{4'd1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 occupancy 5 shows dropped writes
    '{4'd1, 1'b1, 1'b1, 1'b0, 4'd11}, // R11 write counted at once
    '{4'd1, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 read still in flight
    '{4'd1, 1'b0, 1'b0, 1'b1, 4'd11}  // R11 read seen, occupancy 5
  };

  task automatic chk(input logic exp, input int req);
    n_checks++;
    if (paf_n !== exp) begin
      n_fail++;
      $display("FAIL R%0d: paf_n=%b expected %b at %0t", req, paf_n, exp, $time);
    end
  endtask

  // Called at a write-clock falling edge; returns at the next one
  task automatic step(input logic w, input logic r, input logic ld, input logic [PW-1:0] off);
    logic pre;
    wr_en = w;
    rd_en = r;
    ld_en = ld;
    ld_offset = off;
    pre = paf_n;
    #2;
    // R5: the read-clock edge has passed, the write edge has not
    n_checks++;
    if (paf_n !== pre) begin
      n_fail++;
      $display("FAIL R5: paf_n=%b expected %b after read edge", paf_n, pre);
    end
    @(negedge clk_w);
    wr_en = 1'b0;
    rd_en = 1'b0;
    ld_en = 1'b0;
  endtask

  task automatic do_reset(input logic fw);
    @(negedge clk_w);
    rst = 1'b1;
    fwft_mode = fw;
    repeat (2) @(negedge clk_w);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    // R1 state after reset
    do_reset(1'b0);
    chk(1'b1, 1);

    // R8 load offset 2; the load edge itself still uses offset 0
    step(1'b0, 1'b0, 1'b1, PW'(2));
    chk(1'b1, 8);
    step(1'b0, 1'b0, 1'b0, '0);
    chk(1'b1, 8);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(TBL[i].n); k++)
        step(TBL[i].wr, TBL[i].rd, 1'b0, '0);
      chk(TBL[i].exp, int'(TBL[i].req));
    end

    // R1 reset while the flag is active
    step(1'b1, 1'b0, 1'b0, '0);  // occupancy 6
    chk(1'b0, 1);
    do_reset(1'b0);
    chk(1'b1, 1);

    // R9 offsets at or above D give a zero threshold
    step(1'b0, 1'b0, 1'b1, PW'(9));
    chk(1'b1, 8);                // R8 old offset still in use
    step(1'b0, 1'b0, 1'b0, '0);
    chk(1'b0, 9);                // empty, yet active
    step(1'b0, 1'b0, 1'b1, PW'(8));
    step(1'b0, 1'b0, 1'b0, '0);
    chk(1'b0, 9);
    step(1'b0, 1'b0, 1'b1, PW'(7));
    step(1'b0, 1'b0, 1'b0, '0);
    chk(1'b1, 9);                // threshold 1, empty
    step(1'b1, 1'b0, 1'b0, '0);
    chk(1'b0, 2);                // one word reaches threshold 1

    // R6 fall-through mode: D = 9, offset 2, threshold 7
    do_reset(1'b1);
    chk(1'b1, 1);
    step(1'b0, 1'b0, 1'b1, PW'(2));
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, '0);
    chk(1'b1, 6);                // occupancy 6, a standard-mode depth would assert here
    step(1'b1, 1'b0, 1'b0, '0);
    chk(1'b0, 6);                // occupancy 7
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0, '0);
    chk(1'b0, 7);                // capped at 9
    for (int k = 0; k < 2; k++) step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk(1'b0, 6);                // 9 - 2 = 7, still at threshold
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
    chk(1'b1, 6);                // occupancy 6

    finish_run();
  end
endmodule